// File: doc/BRIEF.md
# Panel Setup Sequence Player

This block brings a small display panel out of power-down and configures it over a byte-wide write port. On a power-up request it first releases the panel's reset line and waits. It then turns on the panel's enable line and waits again. After that it plays a fixed list of setup entries held in an internal table. On a shutdown request it plays a second, shorter list from the same table. Each byte leaves the block on a valid/ready handshake with a flag that marks it as a command or as a parameter. A downstream bus cycle generator turns that stream into pin activity.

Each table entry starts with three header bytes: a kind byte (0 for command bytes, 1 for parameter bytes), a wait in milliseconds, and a byte count. The payload bytes follow the header. The block does not wait before an entry. It sends all the payload bytes first and then holds for the stated number of milliseconds. A kind byte of 0xFF ends a list. The millisecond time base comes from the system clock through a prescaler, so a bench can run with a much shorter millisecond. A done flag rises once the last entry of a list, including its wait, has finished.

Top module: `panel_seq_player`

## Requirements
- R1: While reset is held and right after it, the panel reset pin is low, the panel enable pin is high (disabled), wr_valid_o is low and done_o is low.
- R2: A power-up request in idle drives the panel reset pin high on the next clock. The enable pin goes low exactly RST_WAIT_MS*TICK_DIV clocks later. The first byte is offered exactly EN_WAIT_MS*TICK_DIV+1 clocks after the enable pin falls. The enable pin is never low while the reset pin is low.
- R3: The power-up list produces this sequence of (byte, wr_is_data_o) pairs, where 0 means command and 1 means parameter: (3A,0)(55,1)(C5,0)(00,1)(22,1)(80,1)(36,0)(48,1)(11,0)(29,0)(2C,0). The three parameter bytes after C5 come from one entry whose count is 3.
- R4: While wr_valid_o is high and wr_ready_i is low, wr_valid_o stays high and wr_byte_o and wr_is_data_o do not change. The block never moves to the next byte without a handshake.
- R5: The wait of an entry comes after its last byte. The byte after 11 is offered no sooner than 120 ms (0x78) after 11 is accepted, and the byte after 29 no sooner than 50 ms (0x32) after 29 is accepted.
- R6: done_o rises only after the last entry's wait has expired. done_o is low whenever wr_valid_o is high, and it clears on the clock that accepts a new request.
- R7: A shutdown request in idle plays (28,0) with a 10 ms wait, then (10,0) with a 120 ms wait, and then raises done_o. The panel reset and enable pins do not change.
- R8: Requests that arrive while a list or the power-up waits are in progress are ignored. The stream does not restart and the panel pins do not change.
- R9: If power-up and shutdown requests arrive in the same idle clock, the power-up sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req_i | input | 1 | Request to run the power-up sequence and the setup list |
| down_req_i | input | 1 | Request to play the shutdown list |
| wr_valid_o | output | 1 | A byte is offered downstream |
| wr_byte_o | output | 8 | Offered byte |
| wr_is_data_o | output | 1 | 0 = command byte, 1 = parameter byte |
| wr_ready_i | input | 1 | Downstream accepts the offered byte |
| lcd_rst_n_o | output | 1 | Panel reset, active low |
| lcd_en_n_o | output | 1 | Panel enable, active low |
| done_o | output | 1 | The last list played has fully finished |

## Verification
A new request can land in the same clock as a byte handshake, a header fetch or the final tick of an entry's wait. The only cases in which such a request is not simply discarded are when the block is idle, or when both requests arrive together in idle. The bench drives the playback with pseudo-random ready and pulses both request lines at fixed intervals that do not line up with the stream. These pulses hit handshake clocks and wait expiries. The scoreboard must still see the exact expected byte sequence with no restart and unchanged panel pins. A separate run asserts both requests in one idle clock and expects the power-up stream.

// File: rtl/panel_seq_pkg.sv
// panel_seq_pkg: shared constants, controller state type and the setup table.
// Assumes the table fits in ROM_DEPTH bytes and every list ends with END_MARK.
package panel_seq_pkg;

    localparam int ROM_DEPTH = 48;
    localparam int ROM_AW    = $clog2(ROM_DEPTH + 16);
    localparam int DLY_W     = 8;
    localparam int CNT_W     = 8;
    localparam int UP_BASE   = 0;
    localparam int DOWN_BASE = 39;
    localparam logic [7:0] END_MARK = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_WAIT,
        ST_EN_WAIT,
        ST_FETCH,
        ST_SEND,
        ST_HOLD
    } seq_state_t;

    // Table contents: entries of {kind, wait_ms, count, payload...}.
    function automatic logic [7:0] rom_byte(input logic [ROM_AW-1:0] a);
        logic [7:0] v;
        case (a)
            6'd0, 6'd1, 6'd5, 6'd8, 6'd9, 6'd13, 6'd15, 6'd18, 6'd19,
            6'd23, 6'd26, 6'd30, 6'd34, 6'd35, 6'd39, 6'd43:      v = 8'h00;
            6'd2, 6'd4, 6'd6, 6'd10, 6'd12, 6'd20, 6'd22, 6'd24,
            6'd28, 6'd32, 6'd36, 6'd41, 6'd45:                   v = 8'h01;
            6'd3:  v = 8'h3A;
            6'd7:  v = 8'h55;
            6'd11: v = 8'hC5;
            6'd14: v = 8'h03;
            6'd16: v = 8'h22;
            6'd17: v = 8'h80;
            6'd21: v = 8'h36;
            6'd25: v = 8'h48;
            6'd27: v = 8'h78;
            6'd29: v = 8'h11;
            6'd31: v = 8'h32;
            6'd33: v = 8'h29;
            6'd37: v = 8'h2C;
            6'd40: v = 8'h0A;
            6'd42: v = 8'h28;
            6'd44: v = 8'h78;
            6'd46: v = 8'h10;
            default: v = END_MARK;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/seq_rom.sv
// seq_rom: multi-port combinational read of the setup table.
// Assumes addresses beyond the table read as the end marker.
module seq_rom
    import panel_seq_pkg::*;
#(
    parameter int NPORT = 3
) (
    input  logic [NPORT-1:0][ROM_AW-1:0] addr_i,
    output logic [NPORT-1:0][7:0]        data_o
);

    // One table lookup per read port.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign data_o[p] = rom_byte(addr_i[p]);
    end

endmodule

// File: rtl/ms_timer.sv
// ms_timer: loadable millisecond down-counter with a clock prescaler.
// Assumes load_i is never given ms_i == 0; expire_o pulses in the last clock
// of exactly ms_i*TICK_DIV clocks after the load edge.
module ms_timer #(
    parameter int TICK_DIV = 250000,
    parameter int MS_W     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [MS_W-1:0] ms_i,
    output logic            expire_o
);

    localparam int PW = $clog2(TICK_DIV + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0]   pre_q;
    logic [MS_W-1:0] left_q;

    // Prescaler and remaining-millisecond count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            left_q <= '0;
        end else if (load_i) begin
            pre_q  <= '0;
            left_q <= ms_i;
        end else if (left_q != '0) begin
            if (pre_q == PRE_LAST) begin
                pre_q  <= '0;
                left_q <= left_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // Last clock of the final millisecond.
    assign expire_o = (left_q == MS_W'(1)) && (pre_q == PRE_LAST);

endmodule

// File: rtl/seq_ctrl.sv
// seq_ctrl: power-up pin sequencing and table walker.
// Assumes the table port returns bytes at ptr, ptr+1 and ptr+2 in the same
// clock; requests are accepted only in idle, power-up has priority.
module seq_ctrl
    import panel_seq_pkg::*;
#(
    parameter int RST_WAIT_MS = 10,
    parameter int EN_WAIT_MS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req_i,
    input  logic              down_req_i,
    input  logic [2:0][7:0]   rom_d_i,
    output logic [ROM_AW-1:0] ptr_o,
    input  logic              expire_i,
    output logic              tmr_load_o,
    output logic [DLY_W-1:0]  tmr_ms_o,
    output logic              wr_valid_o,
    output logic [7:0]        wr_byte_o,
    output logic              wr_is_data_o,
    input  logic              wr_ready_i,
    output logic              lcd_rst_n_o,
    output logic              lcd_en_n_o,
    output logic              done_o
);

    seq_state_t        state_q;
    logic [ROM_AW-1:0] ptr_q;
    logic              kind_q;
    logic [DLY_W-1:0]  dly_q;
    logic [CNT_W-1:0]  left_q;
    logic              rst_pin_q;
    logic              en_pin_q;
    logic              done_q;

    logic last_byte;
    assign last_byte = (left_q == CNT_W'(1));

    // Timer load requests on entering a wait.
    always_comb begin
        tmr_load_o = 1'b0;
        tmr_ms_o   = '0;
        case (state_q)
            ST_IDLE: if (up_req_i) begin
                tmr_load_o = 1'b1;
                tmr_ms_o   = DLY_W'(RST_WAIT_MS);
            end
            ST_RST_WAIT: if (expire_i) begin
                tmr_load_o = 1'b1;
                tmr_ms_o   = DLY_W'(EN_WAIT_MS);
            end
            ST_FETCH: if (rom_d_i[0] != END_MARK && rom_d_i[2] == '0
                          && rom_d_i[1] != '0) begin
                tmr_load_o = 1'b1;
                tmr_ms_o   = rom_d_i[1];
            end
            ST_SEND: if (wr_ready_i && last_byte && dly_q != '0) begin
                tmr_load_o = 1'b1;
                tmr_ms_o   = dly_q;
            end
            default: ;
        endcase
    end

    // Sequencer state, table pointer, entry header and panel pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ptr_q     <= '0;
            kind_q    <= 1'b0;
            dly_q     <= '0;
            left_q    <= '0;
            rst_pin_q <= 1'b0;
            en_pin_q  <= 1'b1;
            done_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (up_req_i) begin
                        rst_pin_q <= 1'b1;
                        done_q    <= 1'b0;
                        state_q   <= ST_RST_WAIT;
                    end else if (down_req_i) begin
                        done_q  <= 1'b0;
                        ptr_q   <= ROM_AW'(DOWN_BASE);
                        state_q <= ST_FETCH;
                    end
                end
                ST_RST_WAIT: if (expire_i) begin
                    en_pin_q <= 1'b0;
                    state_q  <= ST_EN_WAIT;
                end
                ST_EN_WAIT: if (expire_i) begin
                    ptr_q   <= ROM_AW'(UP_BASE);
                    state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (rom_d_i[0] == END_MARK) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        kind_q <= rom_d_i[0][0];
                        dly_q  <= rom_d_i[1];
                        left_q <= rom_d_i[2];
                        ptr_q  <= ptr_q + ROM_AW'(3);
                        if (rom_d_i[2] != '0)      state_q <= ST_SEND;
                        else if (rom_d_i[1] != '0) state_q <= ST_HOLD;
                        else                       state_q <= ST_FETCH;
                    end
                end
                ST_SEND: if (wr_ready_i) begin
                    ptr_q  <= ptr_q + 1'b1;
                    left_q <= left_q - 1'b1;
                    if (last_byte)
                        state_q <= (dly_q != '0) ? ST_HOLD : ST_FETCH;
                end
                ST_HOLD: if (expire_i) state_q <= ST_FETCH;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ptr_o        = ptr_q;
    assign wr_valid_o   = (state_q == ST_SEND);
    assign wr_byte_o    = rom_d_i[0];
    assign wr_is_data_o = kind_q;
    assign lcd_rst_n_o  = rst_pin_q;
    assign lcd_en_n_o   = en_pin_q;
    assign done_o       = done_q;

endmodule

// File: rtl/panel_seq_player.sv
// panel_seq_player: top of the panel setup sequence player.
// Assumes wr_ready_i follows the usual valid/ready rules; pixel traffic and
// bus pin timing live downstream.
module panel_seq_player
    import panel_seq_pkg::*;
#(
    parameter int TICK_DIV    = 250000,
    parameter int RST_WAIT_MS = 10,
    parameter int EN_WAIT_MS  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_req_i,
    input  logic       down_req_i,
    output logic       wr_valid_o,
    output logic [7:0] wr_byte_o,
    output logic       wr_is_data_o,
    input  logic       wr_ready_i,
    output logic       lcd_rst_n_o,
    output logic       lcd_en_n_o,
    output logic       done_o
);

    logic [ROM_AW-1:0]      ptr;
    logic [2:0][ROM_AW-1:0] rom_a;
    logic [2:0][7:0]        rom_d;
    logic                   tmr_load;
    logic [DLY_W-1:0]       tmr_ms;
    logic                   tmr_expire;

    // Header bytes are read side by side from the pointer.
    for (genvar i = 0; i < 3; i++) begin : g_addr
        assign rom_a[i] = ptr + ROM_AW'(i);
    end

    seq_rom #(.NPORT(3)) u_rom (
        .addr_i (rom_a),
        .data_o (rom_d)
    );

    ms_timer #(.TICK_DIV(TICK_DIV), .MS_W(DLY_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .ms_i     (tmr_ms),
        .expire_o (tmr_expire)
    );

    seq_ctrl #(.RST_WAIT_MS(RST_WAIT_MS), .EN_WAIT_MS(EN_WAIT_MS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .up_req_i     (up_req_i),
        .down_req_i   (down_req_i),
        .rom_d_i      (rom_d),
        .ptr_o        (ptr),
        .expire_i     (tmr_expire),
        .tmr_load_o   (tmr_load),
        .tmr_ms_o     (tmr_ms),
        .wr_valid_o   (wr_valid_o),
        .wr_byte_o    (wr_byte_o),
        .wr_is_data_o (wr_is_data_o),
        .wr_ready_i   (wr_ready_i),
        .lcd_rst_n_o  (lcd_rst_n_o),
        .lcd_en_n_o   (lcd_en_n_o),
        .done_o       (done_o)
    );

endmodule

// File: rtl/panel_seq_player_chk.sv
// panel_seq_player_chk: port-level properties of the sequence player.
// Assumes synchronous active-low reset; attached to every instance by bind.
module panel_seq_player_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       up_req_i,
    input logic       down_req_i,
    input logic       wr_valid_o,
    input logic [7:0] wr_byte_o,
    input logic       wr_is_data_o,
    input logic       wr_ready_i,
    input logic       lcd_rst_n_o,
    input logic       lcd_en_n_o,
    input logic       done_o
);

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_byte_o) && $stable(wr_is_data_o))); // R4

    AST_EN_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_en_n_o |-> lcd_rst_n_o); // R2

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_valid_o); // R6

    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && (up_req_i || down_req_i)) |=> ($stable(lcd_rst_n_o) && $stable(lcd_en_n_o))); // R8

    AST_DONE_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !wr_valid_o); // R6

endmodule

bind panel_seq_player panel_seq_player_chk u_chk (.*);

// File: tb/tb_panel_seq_player.sv
module tb_panel_seq_player;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_req_i = 1'b0;
    logic       down_req_i = 1'b0;
    logic       wr_valid_o;
    logic [7:0] wr_byte_o;
    logic       wr_is_data_o;
    logic       wr_ready_i = 1'b1;
    logic       lcd_rst_n_o;
    logic       lcd_en_n_o;
    logic       done_o;

    always #2 clk = ~clk;

    panel_seq_player #(.TICK_DIV(DIV), .RST_WAIT_MS(10), .EN_WAIT_MS(20)) dut (.*);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] b;
        logic       d;
        int         gap;
    } exp_t;
    exp_t q[$];
    exp_t e;
    int last_acc = 0;
    int acc_count = 0;

    // 0: ready high, 1: pseudo-random, 2: ready low
    int rdy_mode = 0;
    logic [7:0] lfsr = 8'h5A;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic d, input int gap);
        exp_t x;
        x.b = b; x.d = d; x.gap = gap;
        q.push_back(x);
    endtask

    task automatic push_up_list();
        push(8'h3A, 0, 0); push(8'h55, 1, 0);
        push(8'hC5, 0, 0); push(8'h00, 1, 0); push(8'h22, 1, 0); push(8'h80, 1, 0);
        push(8'h36, 0, 0); push(8'h48, 1, 0);
        push(8'h11, 0, 0); push(8'h29, 0, 120 * DIV); push(8'h2C, 0, 50 * DIV);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // Ready driver, changes on the falling edge.
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rdy_mode)
            0:       wr_ready_i <= 1'b1;
            1:       wr_ready_i <= lfsr[0];
            default: wr_ready_i <= 1'b0;
        endcase
    end

    // Scoreboard monitor: pops and compares every accepted byte.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && wr_valid_o && wr_ready_i) begin
            if (q.size() == 0) begin
                chk(0, "R3", "unexpected byte", int'(wr_byte_o), 0);
            end else begin
                e = q.pop_front();
                chk(wr_byte_o == e.b, "R3", "byte", int'(wr_byte_o), int'(e.b));
                chk(wr_is_data_o == e.d, "R3", "cmd/data flag", int'(wr_is_data_o), int'(e.d));
                if (e.gap > 0)
                    chk(cyc - last_acc >= e.gap, "R5", "wait after entry", cyc - last_acc, e.gap);
            end
            last_acc = cyc;
            acc_count++;
        end
    end

    task automatic wait_done(input int limit, input string req);
        int n = 0;
        while (!done_o && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(done_o == 1'b1, req, "done raised", int'(done_o), 1);
    endtask

    task automatic check_reset_state();
        chk(lcd_rst_n_o == 1'b0, "R1", "panel reset low", int'(lcd_rst_n_o), 0);
        chk(lcd_en_n_o == 1'b1, "R1", "panel enable off", int'(lcd_en_n_o), 1);
        chk(wr_valid_o == 1'b0, "R1", "valid low", int'(wr_valid_o), 0);
        chk(done_o == 1'b0, "R1", "done low", int'(done_o), 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int c0, c1, c2, n;
        logic [7:0] held;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        // Power-up with random ready, stray requests while busy (R2, R3, R5, R8)
        push_up_list();
        rdy_mode = 1;
        acc_count = 0;
        up_req_i = 1'b1;
        @(negedge clk);
        up_req_i = 1'b0;
        chk(lcd_rst_n_o == 1'b1, "R2", "reset released", int'(lcd_rst_n_o), 1);
        c0 = cyc;
        n = 0;
        while (lcd_en_n_o && n < 2000) begin @(negedge clk); n++; end
        c1 = cyc;
        chk(c1 - c0 == 10 * DIV, "R2", "reset-to-enable clocks", c1 - c0, 10 * DIV);
        n = 0;
        while (!wr_valid_o && n < 2000) begin @(negedge clk); n++; end
        c2 = cyc;
        chk(c2 - c1 == 20 * DIV + 1, "R2", "enable-to-first-byte clocks", c2 - c1, 20 * DIV + 1);
        n = 0;
        while (!done_o && n < 5000) begin
            down_req_i = (n % 13 == 5);
            up_req_i   = (n % 29 == 11);
            @(negedge clk);
            n++;
        end
        down_req_i = 1'b0;
        up_req_i = 1'b0;
        chk(done_o == 1'b1, "R6", "done after power-up list", int'(done_o), 1);
        chk(q.size() == 0, "R3", "bytes left unsent", q.size(), 0);
        chk(acc_count == 11, "R8", "accepted count, no restart", acc_count, 11);
        chk(lcd_rst_n_o == 1'b1 && lcd_en_n_o == 1'b0, "R8", "pins kept",
            {lcd_rst_n_o, lcd_en_n_o}, 2);

        // Shutdown list (R6, R7, R5)
        repeat (3) @(negedge clk);
        push(8'h28, 0, 0);
        push(8'h10, 0, 10 * DIV);
        rdy_mode = 0;
        acc_count = 0;
        down_req_i = 1'b1;
        @(negedge clk);
        down_req_i = 1'b0;
        chk(done_o == 1'b0, "R6", "done cleared by request", int'(done_o), 0);
        wait_done(3000, "R7");
        chk(cyc - last_acc >= 120 * DIV, "R7", "final wait before done", cyc - last_acc, 120 * DIV);
        chk(acc_count == 2 && q.size() == 0, "R7", "shutdown bytes", acc_count, 2);
        chk(lcd_rst_n_o == 1'b1 && lcd_en_n_o == 1'b0, "R7", "pins unchanged",
            {lcd_rst_n_o, lcd_en_n_o}, 2);

        // Reset again, then both requests in one idle clock (R1, R9, R4)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        push_up_list();
        rdy_mode = 2;
        acc_count = 0;
        up_req_i = 1'b1;
        down_req_i = 1'b1;
        @(negedge clk);
        up_req_i = 1'b0;
        down_req_i = 1'b0;
        chk(lcd_rst_n_o == 1'b1, "R9", "power-up chosen", int'(lcd_rst_n_o), 1);
        n = 0;
        while (!wr_valid_o && n < 2000) begin @(negedge clk); n++; end
        held = wr_byte_o;
        repeat (6) @(negedge clk);
        chk(wr_valid_o == 1'b1, "R4", "valid held without ready", int'(wr_valid_o), 1);
        chk(wr_byte_o == held && held == 8'h3A, "R4", "byte held without ready", int'(wr_byte_o), 8'h3A);
        rdy_mode = 1;
        wait_done(5000, "R9");
        chk(acc_count == 11 && q.size() == 0, "R9", "power-up stream played", acc_count, 11);

        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

endmodule